// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address. It does this by reading a radix page table from memory. The table has three levels, and each level is indexed by 9 bits of the address. The walk starts from a root table. A translation control word gives the root table's physical page number and a mode field. With one mode value the block translates. With any other value the address passes through unchanged.

Each request carries:
- the virtual address,
- an access kind (read, write or instruction fetch),
- the privilege of the requester (user or supervisor).

The walker fetches one 8-byte entry per level through a simple read port that uses a valid/ready handshake. It stops at the first leaf entry or at the first fault. It then returns, for one cycle, either a physical address with the leaf's low flag byte or a page-fault flag. Only one walk is in flight at a time. A leaf found above the last level maps a large page (2 MB or 1 GB), and the untranslated low bits of the virtual address pass into the physical address.

Top module: `sv39_walker`

## Requirements
- R1: The address of each entry read is table_base + index*8. The first read uses table_base = root PPN << 12 and index = VA[38:30]. Later reads use VA[29:21] and then VA[20:12].
- R2: When translating, a virtual address whose bits 63:38 are not all equal faults. It makes no memory read, and rsp_valid rises in the cycle after acceptance.
- R3: The control word's mode is bits 63:60 and the root PPN is bits 43:0. Mode 8 translates. Any other mode returns rsp_paddr = VA[55:0], flags 0 and no fault, with no memory read, in the cycle after acceptance.
- R4: A valid entry with R, W and X all clear (bits 1, 2, 3) is a pointer. The next read uses table_base = PTE[53:10] << 12 at the next lower level.
- R5: Entry bit positions are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, and the PPN is in 53:10. A level-0 leaf gives rsp_paddr = {PPN, VA[11:0]} and rsp_flags = PTE[7:0].
- R6: A leaf at level 1 gives {PPN[43:9], VA[20:0]}. A leaf at level 2 gives {PPN[43:18], VA[29:0]}.
- R7: A level-1 leaf with PPN[8:0] nonzero, or a level-2 leaf with PPN[17:0] nonzero, faults.
- R8: An entry with V clear faults. An entry with W set and R clear faults. A pointer entry read at level 0 faults.
- R9: Access codes are 00 read, 01 write and 10 fetch. A read needs R, a write needs W and a fetch needs X; otherwise the walk faults.
- R10: With req_user=1 the leaf must have U set. With req_user=0 a leaf with U set faults.
- R11: req_ready is low from acceptance until the cycle after rsp_valid. An unaccepted memory request keeps mem_req_valid high and mem_req_addr unchanged. A faulting response reports rsp_paddr 0 and rsp_flags 0.
- R12: Entry bits 63:54 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_ctrl | input | 64 | Translation control word: mode, address-space tag, root PPN |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address to translate |
| req_access | input | 2 | 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 = user-mode requester |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Page table entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 56 | Translated physical address |
| rsp_flags | output | 8 | Leaf flag byte |
| rsp_fault | output | 1 | Page fault |

## Verification
Wrong internal state in this block shows up at the ports within one entry fetch:
- A stale level counter or table base changes mem_req_addr on the very next read. That read is compared on its handshake cycle against addresses predicted from the table image.
- A decode fault (wrong leaf test, permission, privilege or alignment) flips rsp_fault or rsp_paddr on the response strobe. That strobe appears in the cycle after the last entry returns.
- A control flaw either lets req_ready rise early or drops a stalled request. The first is caught on any cycle of a walk; the second on the cycle after a refused handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10
   } acc_e;

   typedef enum logic [1:0] {
      W_IDLE,
      W_RD,
      W_WAIT,
      W_DONE
   } wstate_e;

   localparam int PTE_V       = 0;
   localparam int PTE_R       = 1;
   localparam int PTE_W       = 2;
   localparam int PTE_X       = 3;
   localparam int PTE_U       = 4;
   localparam int PTE_PPN_LSB = 10;
   localparam int PTE_BYTES_LG = 3;

endpackage

// File: rtl/ptw_vaddr_split.sv
module ptw_vaddr_split #(
   parameter int VA_W   = 39,
   parameter int LEVELS = 3,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12
) (
   input  logic [63:0]                   vaddr,
   output logic [LEVELS-1:0][IDX_W-1:0]  idx,
   output logic                          canonical
);
   localparam int HI_W = 64 - VA_W + 1;

   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_idx
         assign idx[l] = vaddr[OFF_W + l*IDX_W +: IDX_W];
      end
   endgenerate

   // upper bits, including the top translated bit, must be a sign extension
   logic [HI_W-1:0] hi_bits;
   assign hi_bits   = vaddr[63:VA_W-1];
   assign canonical = (&hi_bits) | ~(|hi_bits);

   logic unused_off;
   assign unused_off = ^vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
   import ptw_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12,
   parameter int PPN_W  = 44,
   parameter int PA_W   = 56,
   parameter int LVL_W  = 2
) (
   input  logic [63:0]       pte,
   input  logic [LVL_W-1:0]  level,
   input  logic [1:0]        access,
   input  logic              user_mode,
   input  logic [PA_W-1:0]   vaddr,
   output logic              fault,
   output logic              leaf_ok,
   output logic              next_ok,
   output logic [PA_W-1:0]   paddr
);
   logic [PPN_W-1:0] ppn;
   assign ppn = pte[PTE_PPN_LSB +: PPN_W];

   logic [LEVELS-1:0][PA_W-1:0] pa_lvl;
   logic [LEVELS-1:0]           mis_lvl;

   // one physical-address candidate and one alignment test per level
   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
         localparam int KEEP = OFF_W + l*IDX_W;
         assign pa_lvl[l] = {ppn[PPN_W-1:l*IDX_W], vaddr[KEEP-1:0]};
         if (l == 0) begin : g_base
            assign mis_lvl[l] = 1'b0;
         end else begin : g_super
            assign mis_lvl[l] = |ppn[l*IDX_W-1:0];
         end
      end
   endgenerate

   logic v, r, w, x, u, is_leaf, perm_ok, priv_ok, bad_enc;

   always_comb begin
      v = pte[PTE_V];
      r = pte[PTE_R];
      w = pte[PTE_W];
      x = pte[PTE_X];
      u = pte[PTE_U];
      is_leaf = r | w | x;
      case (acc_e'(access))
         ACC_WRITE: perm_ok = w;
         ACC_FETCH: perm_ok = x;
         default:   perm_ok = r;
      endcase
      priv_ok = user_mode ? u : ~u;
      bad_enc = ~v | (w & ~r);
      if (bad_enc)
         fault = 1'b1;
      else if (is_leaf)
         fault = ~perm_ok | ~priv_ok | mis_lvl[level];
      else
         fault = (level == '0);
      leaf_ok = ~fault & is_leaf;
      next_ok = ~fault & ~is_leaf;
      paddr   = pa_lvl[level];
   end

   logic unused_pte;
   assign unused_pte = ^{pte[63:PTE_PPN_LSB+PPN_W], pte[PTE_PPN_LSB-1:PTE_U+1]};

endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
   import ptw_pkg::*;
#(
   parameter int VA_W       = 39,
   parameter int LEVELS     = 3,
   parameter int IDX_W      = 9,
   parameter int OFF_W      = 12,
   parameter int PPN_W      = 44,
   parameter int PA_W       = 56,
   parameter int XLATE_MODE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       xlate_ctrl,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [63:0]       req_vaddr,
   input  logic [1:0]        req_access,
   input  logic              req_user,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_data,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic [7:0]        rsp_flags,
   output logic              rsp_fault
);
   localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int TOP_LVL = LEVELS - 1;
   localparam int PAD_W   = PA_W - IDX_W - PTE_BYTES_LG;

   // elaboration-time parameter checks
   generate
      if (VA_W != LEVELS*IDX_W + OFF_W) begin : g_bad_va
         $error("VA_W must equal LEVELS*IDX_W+OFF_W");
      end
      if (PA_W != PPN_W + OFF_W) begin : g_bad_pa
         $error("PA_W must equal PPN_W+OFF_W");
      end
      if (PA_W > 64 || PPN_W + PTE_PPN_LSB > 64 || PPN_W > 60) begin : g_bad_w
         $error("PPN does not fit the entry or control word");
      end
      if (XLATE_MODE > 15) begin : g_bad_mode
         $error("XLATE_MODE must fit four bits");
      end
   endgenerate

   wstate_e          st_q;
   logic [63:0]      va_q;
   logic [1:0]       acc_q;
   logic             usr_q;
   logic [PA_W-1:0]  base_q, pa_q;
   logic [7:0]       fl_q;
   logic             flt_q;
   logic [LVL_W-1:0] lvl_q;

   logic [63:0]                  va_sel;
   logic [LEVELS-1:0][IDX_W-1:0] idx;
   logic                         canon;
   logic [IDX_W-1:0]             idx_cur;
   logic                         mode_xlate, accept;
   logic                         dec_fault, dec_leaf, dec_next;
   logic [PA_W-1:0]              dec_pa;

   assign va_sel = (st_q == W_IDLE) ? req_vaddr : va_q;

   ptw_vaddr_split #(
      .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) u_split (
      .vaddr(va_sel), .idx(idx), .canonical(canon)
   );

   ptw_pte_decode #(
      .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W),
      .PPN_W(PPN_W), .PA_W(PA_W), .LVL_W(LVL_W)
   ) u_dec (
      .pte(mem_rsp_data), .level(lvl_q), .access(acc_q), .user_mode(usr_q),
      .vaddr(va_q[PA_W-1:0]), .fault(dec_fault), .leaf_ok(dec_leaf),
      .next_ok(dec_next), .paddr(dec_pa)
   );

   assign mode_xlate    = (xlate_ctrl[63:60] == 4'(XLATE_MODE));
   assign req_ready     = (st_q == W_IDLE);
   assign accept        = req_valid & req_ready;
   assign idx_cur       = idx[lvl_q];
   assign mem_req_valid = (st_q == W_RD);
   assign mem_req_addr  = base_q + {{PAD_W{1'b0}}, idx_cur, {PTE_BYTES_LG{1'b0}}};
   assign rsp_valid     = (st_q == W_DONE);
   assign rsp_paddr     = pa_q;
   assign rsp_flags     = fl_q;
   assign rsp_fault     = flt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         va_q   <= '0;
         acc_q  <= '0;
         usr_q  <= 1'b0;
         base_q <= '0;
         pa_q   <= '0;
         fl_q   <= '0;
         flt_q  <= 1'b0;
         lvl_q  <= '0;
      end else begin
         case (st_q)
            W_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  acc_q  <= req_access;
                  usr_q  <= req_user;
                  lvl_q  <= LVL_W'(TOP_LVL);
                  base_q <= {xlate_ctrl[PPN_W-1:0], {OFF_W{1'b0}}};
                  pa_q   <= '0;
                  fl_q   <= '0;
                  flt_q  <= 1'b0;
                  if (!mode_xlate) begin
                     pa_q <= req_vaddr[PA_W-1:0];
                     st_q <= W_DONE;
                  end else if (!canon) begin
                     flt_q <= 1'b1;
                     st_q  <= W_DONE;
                  end else begin
                     st_q <= W_RD;
                  end
               end
            end
            W_RD: begin
               if (mem_req_ready) st_q <= W_WAIT;
            end
            W_WAIT: begin
               if (mem_rsp_valid) begin
                  if (dec_fault) begin
                     flt_q <= 1'b1;
                     st_q  <= W_DONE;
                  end else if (dec_leaf) begin
                     pa_q <= dec_pa;
                     fl_q <= mem_rsp_data[7:0];
                     st_q <= W_DONE;
                  end else begin
                     base_q <= {mem_rsp_data[PTE_PPN_LSB +: PPN_W], {OFF_W{1'b0}}};
                     lvl_q  <= lvl_q - 1'b1;
                     st_q   <= W_RD;
                  end
               end
            end
            W_DONE:  st_q <= W_IDLE;
            default: st_q <= W_IDLE;
         endcase
      end
   end

   logic unused_ctrl;
   assign unused_ctrl = ^xlate_ctrl[59:PPN_W];

   // assertions
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   p_single_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   p_bare_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !mode_xlate |=> rsp_valid && !rsp_fault && !mem_req_valid);

   p_noncanon_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept && mode_xlate && !canon |=> rsp_valid && rsp_fault && !mem_req_valid);

   p_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == W_WAIT) && mem_rsp_valid && dec_next |=>
         mem_req_valid && (lvl_q == $past(lvl_q) - 1'b1));

   p_lvl0_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == W_WAIT) && mem_rsp_valid && (lvl_q == '0) |-> !dec_next);

   p_fault_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> (rsp_paddr == '0) && (rsp_flags == '0));

endmodule

// File: tb/sv39_walker_tb.sv
`timescale 1ns/1ps
module sv39_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] xlate_ctrl = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_access = '0;
   logic        req_user = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        rsp_valid;
   logic [55:0] rsp_paddr;
   logic [7:0]  rsp_flags;
   logic        rsp_fault;

   always #2 clk = ~clk;

   sv39_walker u_dut (
      .clk(clk), .rst_n(rst_n), .xlate_ctrl(xlate_ctrl),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_access(req_access), .req_user(req_user),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_flags(rsp_flags), .rsp_fault(rsp_fault)
   );

   int n_chk = 0;
   int n_err = 0;
   int n_reads = 0;
   bit done = 0;
   logic [63:0] pmem [logic [55:0]];
   logic [55:0] exp_addr [$];

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [9:0] fl);
      return {10'h0, ppn, fl};
   endfunction

   // behavioural reference: predicts reads and the result
   function automatic void ref_walk(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                                    input logic [63:0] ctl, output logic flt,
                                    output logic [55:0] pa, output logic [7:0] fl);
      logic [55:0] base, a, msk;
      logic [63:0] pte;
      logic need;
      flt = 0; pa = 0; fl = 0;
      if (ctl[63:60] != 4'd8) begin pa = va[55:0]; return; end
      if (!(va[63:38] == '0 || va[63:38] == {26{1'b1}})) begin flt = 1; return; end
      base = {ctl[43:0], 12'h0};
      for (int lvl = 2; lvl >= 0; lvl--) begin
         a = base + ((va[55:0] >> (12 + 9*lvl)) & 56'h1FF) * 8;
         exp_addr.push_back(a);
         pte = pmem.exists(a) ? pmem[a] : 64'h0;
         if (!pte[0] || (pte[2] && !pte[1])) begin flt = 1; return; end
         if (pte[3:1] == 3'b000) begin
            if (lvl == 0) begin flt = 1; return; end
            base = {pte[53:10], 12'h0};
            continue;
         end
         need = (acc == 2'b01) ? pte[2] : (acc == 2'b10) ? pte[3] : pte[1];
         if (!need || (usr != pte[4])) begin flt = 1; return; end
         if ((pte[53:10] & ((44'd1 << (9*lvl)) - 1)) != 0) begin flt = 1; return; end
         msk = (56'd1 << (12 + 9*lvl)) - 1;
         pa = ({pte[53:10], 12'h0} & ~msk) | (va[55:0] & msk);
         fl = pte[7:0];
         return;
      end
   endfunction

   // memory responder, checks every accepted read address
   initial begin
      bit pend = 0, stalled = 0;
      logic [55:0] st_addr = '0;
      logic [63:0] word = '0;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         if (pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = word; pend = 0; end
         else begin mem_rsp_valid = 1'b0; mem_rsp_data = 64'hx; end
         if (stalled) begin
            chk(mem_req_valid && mem_req_addr == st_addr, "R11 stalled read held", mem_req_addr, st_addr);
            stalled = 0;
         end
         mem_req_ready = (($urandom % 4) != 0);
         if (rst_n && mem_req_valid && mem_req_ready) begin
            n_reads++;
            if (exp_addr.size() == 0)
               chk(0, "R1 unexpected read", mem_req_addr, 0);
            else begin
               logic [55:0] e;
               e = exp_addr.pop_front();
               chk(mem_req_addr == e, "R1 R4 entry address", mem_req_addr, e);
            end
            word = pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 64'h0;
            pend = 1;
         end else if (rst_n && mem_req_valid) begin
            stalled = 1; st_addr = mem_req_addr;
         end
      end
   end

   task automatic walk(input logic [63:0] va, input logic [1:0] acc, input logic usr, input string tag);
      logic ef; logic [55:0] ep; logic [7:0] efl; int exp_rd; int cyc;
      exp_addr.delete();
      ref_walk(va, acc, usr, xlate_ctrl, ef, ep, efl);
      exp_rd = exp_addr.size();
      n_reads = 0;
      @(negedge clk);
      chk(req_ready && !rsp_valid, {tag, " R11 idle before request"}, req_ready, 1);
      req_valid = 1'b1; req_vaddr = va; req_access = acc; req_user = usr;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_valid && cyc < 200) begin
         chk(!req_ready, {tag, " R11 busy during walk"}, req_ready, 0);
         @(negedge clk);
         cyc++;
      end
      chk(rsp_valid, {tag, " response strobe"}, rsp_valid, 1);
      chk(!req_ready, {tag, " R11 busy at response"}, req_ready, 0);
      chk(rsp_fault == ef, {tag, " fault"}, rsp_fault, ef);
      chk(rsp_paddr == ep, {tag, " paddr"}, rsp_paddr, ep);
      chk(rsp_flags == efl, {tag, " flags"}, rsp_flags, efl);
      chk(exp_addr.size() == 0 && n_reads == exp_rd, {tag, " R1 read count"}, n_reads, exp_rd);
      if (exp_rd == 0) chk(cyc == 1, {tag, " R2 R3 one-cycle response"}, cyc, 1);
      @(negedge clk);
      chk(req_ready && !rsp_valid, {tag, " R11 ready after response"}, req_ready, 1);
   endtask

   localparam logic [55:0] ROOT = 56'h8000_0000;
   localparam logic [55:0] L1A  = 56'h8000_1000;
   localparam logic [55:0] L0A  = 56'h8000_2000;

   initial begin
      pmem[ROOT + 0*8]   = mk(44'h80001, 10'h001);
      pmem[ROOT + 1*8]   = mk(44'h40000, 10'h0CF);
      pmem[ROOT + 2*8]   = mk(44'h40200, 10'h0CF);
      pmem[L1A + 0*8]    = mk(44'h80002, 10'h001);
      pmem[L1A + 1*8]    = mk(44'h90200, 10'h0C3);
      pmem[L1A + 2*8]    = mk(44'h90201, 10'h0C3);
      pmem[L0A + 0*8]    = mk(44'h90000, 10'h0C7);
      pmem[L0A + 1*8]    = mk(44'h90001, 10'h01B);
      pmem[L0A + 2*8]    = mk(44'h90002, 10'h001);
      pmem[L0A + 4*8]    = mk(44'h90004, 10'h005);
      pmem[L0A + 5*8]    = {10'h3FF, 44'h90005, 10'h0C3};
      xlate_ctrl = {4'd8, 16'hABCD, 44'h80000};

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R11 reset state", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

      walk(64'h0000_0ABC, 2'b00, 1'b0, "R1 R4 R5 read leaf");
      chk(rsp_paddr == 56'h9000_0ABC, "R5 literal paddr", rsp_paddr, 56'h9000_0ABC);
      walk(64'h0000_0ABC, 2'b01, 1'b0, "R9 write allowed");
      walk(64'h0000_0ABC, 2'b10, 1'b0, "R9 fetch without X");
      walk(64'h0000_0ABC, 2'b00, 1'b1, "R10 user on supervisor page");
      walk(64'h0000_1234, 2'b10, 1'b1, "R10 user fetch");
      walk(64'h0000_1234, 2'b00, 1'b0, "R10 supervisor on user page");
      walk(64'h0000_2000, 2'b00, 1'b0, "R8 pointer at level 0");
      walk(64'h0000_3000, 2'b00, 1'b0, "R8 invalid entry");
      walk(64'h0000_4000, 2'b01, 1'b0, "R8 W without R");
      walk(64'h0000_5008, 2'b00, 1'b0, "R12 reserved bits");
      chk(rsp_paddr == 56'h9000_5008, "R12 literal paddr", rsp_paddr, 56'h9000_5008);
      walk(64'h0020_1234, 2'b00, 1'b0, "R6 2MB leaf");
      chk(rsp_paddr == 56'h9020_1234, "R6 literal 2MB paddr", rsp_paddr, 56'h9020_1234);
      walk(64'h0040_0000, 2'b00, 1'b0, "R7 misaligned 2MB");
      walk(64'h4765_4321, 2'b10, 1'b0, "R6 1GB leaf");
      chk(rsp_paddr == 56'h4765_4321, "R6 literal 1GB paddr", rsp_paddr, 56'h4765_4321);
      walk(64'h8000_0000, 2'b00, 1'b0, "R7 misaligned 1GB");
      walk(64'h0000_0040_0000_0000, 2'b00, 1'b0, "R2 non-canonical");
      walk(64'h8000_0000_0000_1000, 2'b00, 1'b0, "R2 non-canonical high");
      walk(64'hFFFF_FFC0_0000_0123, 2'b00, 1'b0, "R1 R2 canonical high empty");

      for (int i = 0; i < 40; i++) begin
         logic [63:0] va;
         int sel;
         sel = $urandom % 5;
         case (sel)
            0: va = 64'h0000_0000 + ($urandom % 4096);
            1: va = 64'h0000_1000 + ($urandom % 4096);
            2: va = 64'h0000_5000 + ($urandom % 4096);
            3: va = 64'h0020_0000 + ($urandom & 32'h1F_FFFF);
            default: va = 64'h4000_0000 + ($urandom & 32'h3FFF_FFFF);
         endcase
         walk(va, 2'($urandom % 3), 1'($urandom), "R9 R10 random");
      end

      xlate_ctrl = {4'd0, 16'h0, 44'h80000};
      walk(64'hDEAD_BEEF_1234_5678, 2'b00, 1'b0, "R3 bare mode");
      chk(rsp_paddr == 56'hAD_BEEF_1234_5678, "R3 literal passthrough", rsp_paddr, 56'hAD_BEEF_1234_5678);
      xlate_ctrl = {4'd9, 16'h0, 44'h80000};
      walk(64'h0000_0ABC, 2'b01, 1'b1, "R3 other mode");

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule